// File: doc/BRIEF.md
# Write Burst Beat Address Sequencer

This block takes one write-request descriptor and expands it into the address of every beat of that burst. The descriptor arrives over a VALID/READY handshake. It holds a start address, a beat count minus one, a log2 beat width, a burst mode, a transaction tag and a bundle of access attributes. The block then presents one beat address per cycle on a downstream VALID/READY port and marks the final beat. The tag and the attributes stay fixed for the whole burst. The attributes are passed through and never interpreted.

Three stepping modes are supported. In the fixed mode the same address repeats on every beat. In the incrementing mode the address moves forward one beat width at a time. In the wrapping mode the address moves forward inside an aligned window and wraps back to the window base.

Every descriptor is validated when it is accepted. A descriptor with a bad field produces a one-cycle error pulse with a cause code and no beats. Upstream logic uses the block to drive the address side of a data mover. The downstream stage consumes one address per beat it transfers.

Top module: `wburst_addr_gen`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), and in the first cycle after it, req_ready is 1, beat_valid is 0 and err_pulse is 0. Asserting reset in the middle of a burst drops beat_valid at once.
- R2: The block accepts a descriptor on a clock edge where req_valid and req_ready are both 1. After a valid descriptor is accepted, req_ready stays 0 until the edge that transfers the final beat. From the following cycle on, req_ready is 1 again.
- R3: One cycle after a valid descriptor is accepted, beat_valid is 1 and beat_addr equals the start address.
- R4: When req_burst is 2'b00 (fixed), every beat carries the start address.
- R5: When req_burst is 2'b01 (incrementing), beat n (n >= 1) carries the start address rounded down to the beat width, plus n times the beat width. The beat width in bytes is 2 to the power req_size.
- R6: When req_burst is 2'b10 (wrapping), the window size is the beat width times the beat count, and the window base is the start address rounded down to that size. Beat n carries base + ((start - base + n * width) mod window).
- R7: A burst transfers exactly req_len + 1 beats. beat_last is 1 on the final beat and only on that beat. While beat_ready is 0, beat_addr and beat_last hold their values.
- R8: beat_id and beat_attr equal the req_id and req_attr values captured at acceptance, on every beat of the burst.
- R9: A req_size whose byte count exceeds DATA_BYTES is an error. It sets err_code bit 0.
- R10: A req_burst value of 2'b11 is reserved and is an error. It sets err_code bit 1.
- R11: A wrapping burst is an error, setting err_code bit 2, in either of two cases: its beat count is not 2, 4, 8 or 16, or its start address is not a multiple of the beat width.
- R12: A descriptor with any error is still accepted. One cycle later, err_pulse is 1 for exactly one cycle, and err_code holds the cause bits during that cycle. No beat is produced, and req_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Descriptor offered |
| req_ready | output | 1 | Descriptor can be taken |
| req_addr | input | ADDR_W | Start address |
| req_len | input | 8 | Beat count minus one |
| req_size | input | 3 | log2 of bytes per beat |
| req_burst | input | 2 | 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| req_id | input | ID_W | Transaction tag |
| req_attr | input | 16+USER_W | Attributes {lock, cache[3:0], prot[2:0], qos[3:0], region[3:0], user} |
| beat_valid | output | 1 | Beat address offered |
| beat_ready | input | 1 | Downstream takes the beat |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| beat_id | output | ID_W | Captured tag |
| beat_attr | output | 16+USER_W | Captured attributes |
| err_pulse | output | 1 | One-cycle flag for a rejected descriptor |
| err_code | output | 3 | Cause bits: {wrap shape, reserved mode, size too wide} |

## Verification
The bench builds the block with ADDR_W=16, DATA_BYTES=16, ID_W=4 and USER_W=2. With a 16-byte bus, beat widths from 1 to 16 bytes are legal, so the incrementing and wrapping modes can be exercised at several widths. A size code of 5 then falls just past the bus width, which reaches the size error at its boundary. The 16-bit address keeps the wrap windows and the longest 256-beat incrementing burst short enough to check beat by beat.

// File: rtl/wbag_pkg.sv
package wbag_pkg;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10,
    BURST_RSVD  = 2'b11
  } burst_e;

  // Cause bits; bit order is visible on err_code.
  typedef struct packed {
    logic wrap_bad;
    logic burst_bad;
    logic size_bad;
  } desc_err_t;

  // Bytes carried by one beat for a log2 size code.
  function automatic logic [7:0] beat_bytes(input logic [2:0] size);
    return 8'd1 << size;
  endfunction

  // Wrapping bursts allow 2, 4, 8 or 16 beats (length code = beats - 1).
  function automatic logic wrap_len_ok(input logic [7:0] len);
    return (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
  endfunction

endpackage

// File: rtl/wbag_check.sv
module wbag_check
  import wbag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        len,
  input  logic [2:0]        size,
  input  logic [1:0]        burst,
  output desc_err_t         err
);

  localparam logic [2:0] BUS_LG = 3'($clog2(DATA_BYTES));

  logic [ADDR_W-1:0] width_mask;
  logic              misaligned;
  logic              is_wrap;

  always_comb begin
    width_mask = ADDR_W'(beat_bytes(size)) - ADDR_W'(1);
    misaligned = |(addr & width_mask);
    is_wrap    = (burst == BURST_WRAP);
    err.size_bad  = (size > BUS_LG);
    err.burst_bad = (burst == BURST_RSVD);
    err.wrap_bad  = is_wrap && (!wrap_len_ok(len) || misaligned);
  end

endmodule

// File: rtl/wbag_step.sv
module wbag_step
  import wbag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [7:0]        len,
  input  logic [2:0]        size,
  input  logic [1:0]        burst,
  output logic [ADDR_W-1:0] nxt_addr
);

  // Round down to the beat width, then move one beat forward.
  function automatic logic [ADDR_W-1:0] incr_next(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] w);
    return (a & ~(w - ADDR_W'(1))) + w;
  endfunction

  // Move one beat forward, keeping the window bits of the old address.
  function automatic logic [ADDR_W-1:0] wrap_next(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] w,
                                                  input logic [ADDR_W-1:0] win);
    logic [ADDR_W-1:0] m;
    m = win - ADDR_W'(1);
    return (a & ~m) | ((a + w) & m);
  endfunction

  logic [ADDR_W-1:0] width_w;
  logic [ADDR_W-1:0] window_w;

  always_comb begin
    width_w  = ADDR_W'(beat_bytes(size));
    window_w = width_w * ADDR_W'({1'b0, len} + 9'd1);
    case (burst)
      BURST_INCR: nxt_addr = incr_next(cur_addr, width_w);
      BURST_WRAP: nxt_addr = wrap_next(cur_addr, width_w, window_w);
      default:    nxt_addr = cur_addr;
    endcase
  end

endmodule

// File: rtl/wbag_seq.sv
module wbag_seq
  import wbag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int ATTR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              legal,
  input  desc_err_t         err_in,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [7:0]        d_len,
  input  logic [2:0]        d_size,
  input  logic [1:0]        d_burst,
  input  logic [ID_W-1:0]   d_id,
  input  logic [ATTR_W-1:0] d_attr,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic              beat_ready,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [7:0]        len_q,
  output logic [2:0]        size_q,
  output logic [1:0]        burst_q,
  output logic              beat_last,
  output logic [ID_W-1:0]   id_q,
  output logic [ATTR_W-1:0] attr_q,
  output logic              err_pulse,
  output logic [2:0]        err_q
);

  logic [7:0] beat_cnt;
  logic       beat_fire;
  logic       burst_done;

  assign beat_last  = busy && (beat_cnt == len_q);
  assign beat_fire  = busy && beat_ready;
  assign burst_done = beat_fire && beat_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cur_addr  <= '0;
      beat_cnt  <= '0;
      len_q     <= '0;
      size_q    <= '0;
      burst_q   <= '0;
      id_q      <= '0;
      attr_q    <= '0;
      err_pulse <= 1'b0;
      err_q     <= '0;
    end else begin
      err_pulse <= acc && !legal;
      if (acc) err_q <= err_in;
      if (acc && legal) begin
        busy     <= 1'b1;
        cur_addr <= d_addr;
        beat_cnt <= '0;
        len_q    <= d_len;
        size_q   <= d_size;
        burst_q  <= d_burst;
        id_q     <= d_id;
        attr_q   <= d_attr;
      end else if (beat_fire) begin
        if (burst_done) begin
          busy <= 1'b0;
        end else begin
          cur_addr <= nxt_addr;
          beat_cnt <= beat_cnt + 8'd1;
        end
      end
    end
  end

  // R7: a stalled beat holds its address and last flag
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !beat_ready |=> busy && $stable(cur_addr) && $stable(beat_last));

  // R7: the last flag does not repeat after the final transfer
  a_r7_last_once: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !beat_last);

  // R4: fixed bursts repeat the address
  a_r4_fixed_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !beat_last && burst_q == BURST_FIXED |=> cur_addr == $past(cur_addr));

  // R8: tag and attributes do not move inside a burst
  a_r8_side_stable: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !beat_last |=> $stable(id_q) && $stable(attr_q));

endmodule

// File: rtl/wburst_addr_gen.sv
module wburst_addr_gen
  import wbag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8,
  parameter int ID_W       = 4,
  parameter int USER_W     = 4,
  localparam int ATTR_W    = 16 + USER_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_len,
  input  logic [2:0]        req_size,
  input  logic [1:0]        req_burst,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ATTR_W-1:0] req_attr,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_last,
  output logic [ID_W-1:0]   beat_id,
  output logic [ATTR_W-1:0] beat_attr,
  output logic              err_pulse,
  output logic [2:0]        err_code
);

  desc_err_t         chk_err;
  logic              desc_legal;
  logic              req_fire;
  logic              busy;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] nxt_addr;
  logic [7:0]        len_q;
  logic [2:0]        size_q;
  logic [1:0]        burst_q;

  assign desc_legal = ~|chk_err;
  assign req_ready  = ~busy;
  assign req_fire   = req_valid && req_ready;
  assign beat_valid = busy;
  assign beat_addr  = cur_addr;

  wbag_check #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_check (
    .addr  (req_addr),
    .len   (req_len),
    .size  (req_size),
    .burst (req_burst),
    .err   (chk_err)
  );

  wbag_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr (cur_addr),
    .len      (len_q),
    .size     (size_q),
    .burst    (burst_q),
    .nxt_addr (nxt_addr)
  );

  wbag_seq #(.ADDR_W(ADDR_W), .ID_W(ID_W), .ATTR_W(ATTR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (req_fire),
    .legal      (desc_legal),
    .err_in     (chk_err),
    .d_addr     (req_addr),
    .d_len      (req_len),
    .d_size     (req_size),
    .d_burst    (req_burst),
    .d_id       (req_id),
    .d_attr     (req_attr),
    .nxt_addr   (nxt_addr),
    .beat_ready (beat_ready),
    .busy       (busy),
    .cur_addr   (cur_addr),
    .len_q      (len_q),
    .size_q     (size_q),
    .burst_q    (burst_q),
    .beat_last  (beat_last),
    .id_q       (beat_id),
    .attr_q     (beat_attr),
    .err_pulse  (err_pulse),
    .err_q      (err_code)
  );

  // R3: first beat appears next cycle at the start address
  a_r3_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && desc_legal |=> beat_valid && beat_addr == $past(req_addr));

  // R12: a rejected descriptor pulses the flag and starts nothing
  a_r12_err_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !desc_legal |=> err_pulse && !beat_valid && req_ready);

  // R12: the flag lasts a single cycle
  a_r12_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse || $past(req_fire));

  // R2: intake reopens after the final beat
  a_r2_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_last |=> req_ready && !beat_valid);

endmodule

// File: tb/test_wburst_addr_gen.sv
module test_wburst_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int IW = 4;
  localparam int UW = 2;
  localparam int XW = 16 + UW;

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  len;
    logic [2:0]  size;
    logic [1:0]  burst;
    logic [2:0]  exp_err;
    logic        stall;
  } vec_t;

  // start, len, size, burst, expected cause bits, stall downstream
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{16'h0100, 8'd3,   3'd2, 2'b01, 3'b000, 1'b0},  // R5
    '{16'h0103, 8'd2,   3'd2, 2'b01, 3'b000, 1'b1},  // R5 unaligned start
    '{16'h0200, 8'd3,   3'd3, 2'b00, 3'b000, 1'b1},  // R4
    '{16'h0134, 8'd3,   3'd2, 2'b10, 3'b000, 1'b0},  // R6
    '{16'h0048, 8'd7,   3'd3, 2'b10, 3'b000, 1'b1},  // R6
    '{16'h1000, 8'd0,   3'd4, 2'b01, 3'b000, 1'b0},  // R7 single beat
    '{16'h00A7, 8'd15,  3'd0, 2'b10, 3'b000, 1'b0},  // R6 16 beats
    '{16'h1008, 8'd3,   3'd4, 2'b01, 3'b000, 1'b1},  // R5 widest beat
    '{16'h2000, 8'd255, 3'd0, 2'b01, 3'b000, 1'b0},  // R7 256 beats
    '{16'h0000, 8'd3,   3'd5, 2'b01, 3'b001, 1'b0},  // R9
    '{16'h0100, 8'd1,   3'd2, 2'b11, 3'b010, 1'b0},  // R10
    '{16'h0100, 8'd2,   3'd2, 2'b10, 3'b100, 1'b0},  // R11 bad count
    '{16'h0102, 8'd3,   3'd2, 2'b10, 3'b100, 1'b0},  // R11 misaligned
    '{16'h0000, 8'd3,   3'd5, 2'b10, 3'b001, 1'b0}   // R9 with wrap
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_len = '0;
  logic [2:0]    req_size = '0;
  logic [1:0]    req_burst = '0;
  logic [IW-1:0] req_id = '0;
  logic [XW-1:0] req_attr = '0;
  logic          beat_valid;
  logic          beat_ready = 1'b0;
  logic [AW-1:0] beat_addr;
  logic          beat_last;
  logic [IW-1:0] beat_id;
  logic [XW-1:0] beat_attr;
  logic          err_pulse;
  logic [2:0]    err_code;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wburst_addr_gen #(.ADDR_W(AW), .DATA_BYTES(16), .ID_W(IW), .USER_W(UW)) i_wburst_addr_gen (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_len, .req_size,
    .req_burst, .req_id, .req_attr, .beat_valid, .beat_ready, .beat_addr,
    .beat_last, .beat_id, .beat_attr, .err_pulse, .err_code
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent model: address of beat n written as a closed form.
  function automatic logic [15:0] model_addr(input vec_t v, input int n);
    int w, beats, s, win, base;
    w = 1 << v.size;
    beats = int'(v.len) + 1;
    s = int'(v.addr);
    case (v.burst)
      2'b00: return 16'(s);
      2'b01: return (n == 0) ? 16'(s) : 16'((s / w) * w + n * w);
      default: begin
        win = w * beats;
        base = (s / win) * win;
        return 16'(base + ((s - base) + n * w) % win);
      end
    endcase
  endfunction

  task automatic run_vec(input vec_t v, input logic [IW-1:0] id, input logic [XW-1:0] attr);
    int n, k;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = v.addr; req_len = v.len; req_size = v.size;
    req_burst = v.burst; req_id = id; req_attr = attr;
    @(negedge clk);
    // keep offering a different descriptor; it must not be taken mid-burst
    req_addr = ~v.addr; req_id = ~id;
    if (v.exp_err != 3'b000) begin
      req_valid = 1'b0;
      chk(err_pulse == 1'b1, "R12 err_pulse", 32'(err_pulse), 1);
      chk(err_code == v.exp_err, "R9/R10/R11 err_code", 32'(err_code), 32'(v.exp_err));
      chk(beat_valid == 1'b0, "R12 no beat", 32'(beat_valid), 0);
      chk(req_ready == 1'b1, "R12 ready", 32'(req_ready), 1);
      @(negedge clk);
      chk(err_pulse == 1'b0, "R12 pulse width", 32'(err_pulse), 0);
      chk(beat_valid == 1'b0, "R12 still no beat", 32'(beat_valid), 0);
    end else begin
      n = 0; k = 0;
      while (n <= int'(v.len)) begin
        chk(beat_valid == 1'b1, "R3 beat_valid", 32'(beat_valid), 1);
        chk(req_ready == 1'b0, "R2 ready low", 32'(req_ready), 0);
        chk(beat_addr == model_addr(v, n), "R4/R5/R6 beat_addr", 32'(beat_addr), 32'(model_addr(v, n)));
        chk(beat_last == (n == int'(v.len)), "R7 beat_last", 32'(beat_last), 32'(n == int'(v.len)));
        chk(beat_id == id, "R8 beat_id", 32'(beat_id), 32'(id));
        chk(beat_attr == attr, "R8 beat_attr", 32'(beat_attr), 32'(attr));
        beat_ready = !(v.stall && (k % 3 == 0));
        k++;
        if (beat_ready) n++;
        @(negedge clk);
      end
      beat_ready = 1'b0;
      req_valid = 1'b0;
      chk(beat_valid == 1'b0, "R7 beat count", 32'(beat_valid), 0);
      chk(req_ready == 1'b1, "R2 ready back", 32'(req_ready), 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 1);
    chk(beat_valid == 1'b0, "R1 valid in reset", 32'(beat_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    chk(beat_valid == 1'b0, "R1 valid after reset", 32'(beat_valid), 0);
    chk(err_pulse == 1'b0, "R1 err after reset", 32'(err_pulse), 0);

    for (int i = 0; i < NV; i++)
      run_vec(VECS[i], IW'(i), XW'(18'h2A5A5 ^ 18'(i * 37)));

    // R1: reset in the middle of a burst
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0400; req_len = 8'd7; req_size = 3'd1; req_burst = 2'b01;
    @(negedge clk);
    req_valid = 1'b0;
    chk(beat_valid == 1'b1, "R3 burst started", 32'(beat_valid), 1);
    rst_n = 1'b0;
    #1;
    chk(beat_valid == 1'b0, "R1 async drop", 32'(beat_valid), 0);
    chk(req_ready == 1'b1, "R1 ready on reset", 32'(req_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(beat_valid == 1'b0, "R1 idle after reset", 32'(beat_valid), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule